// File: doc/BRIEF.md
# DVMA Page-Table Translation Engine

This block turns a 32-bit device virtual address into a 36-bit physical address. It looks the address up in a single-level page table held in system memory. A device posts an address and a direction flag on a valid/ready request port. The engine then computes where the page-table entry sits and fetches that one 32-bit word over a memory master port. It checks the entry's valid and writable bits and answers on a valid/ready response port. The answer carries the physical address, a permission code and a fault flag.

The table's base and the size of the translation window come in on configuration inputs. Virtual address bits above the window are discarded before the table index is formed. When a lookup fails, the engine does three things in the same cycle: it hands a fault status word and the page-aligned failing address to the register block, and it pulses an interrupt request. Only one translation is in flight at a time, and nothing is cached between lookups.

Top module: `dvma_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_req` and `fault_irq` are 0.
- R2: Window size is 2^(24+`cfg_range`) bytes. The entry address is `cfg_base`*16 plus 4*((`req_va` mod window) >> 12), computed as a 36-bit value and driven on `mem_addr` with `mem_req`.
- R3: The memory port delivers the entry with its bytes swapped: `mem_rdata[7:0]` carries entry bits 31:24, and `mem_rdata[31:24]` carries entry bits 7:0.
- R4: In the entry, bits 31:8 are the physical page number, bit 2 is writable and bit 1 is valid. On success the physical address is (entry AND 0xFFFFFF00)*16 plus VA[11:0]. Entry bits 7 and 0 have no effect on the response.
- R5: A successful response reports `rsp_perm` = 2'b11 (read-write) when the writable bit is set and 2'b01 (read-only) when it is clear.
- R6: An entry with the valid bit clear gives `rsp_fault`=1, `rsp_pa`=0 and `rsp_perm`=2'b00.
- R7: A write request to a valid entry with the writable bit clear faults. A read request to the same entry does not.
- R8: On a fault, `fault_irq` pulses for exactly the first response cycle. With it, `fault_status` is 0xC0820000 for a write or 0xC0860000 for a read, and `fault_addr` is the VA with bits 11:0 cleared.
- R9: From acceptance until the response handshake, `req_ready` stays 0. `mem_req` is held until `mem_gnt`, and exactly one memory request is issued per translation.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 32 | Page-table base (scaled by 16) |
| cfg_range | input | 3 | Window size code |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Engine idle, request accepted |
| req_va | input | 32 | Device virtual address |
| req_write | input | 1 | 1 = write access |
| mem_req | output | 1 | Entry fetch request |
| mem_gnt | input | 1 | Fetch request granted |
| mem_addr | output | 36 | Entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, byte-swapped entry |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_pa | output | 36 | Physical address |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read-write |
| rsp_fault | output | 1 | Translation fault |
| fault_irq | output | 1 | One-cycle fault interrupt strobe |
| fault_status | output | 32 | Fault status word |
| fault_addr | output | 32 | Page-aligned faulting VA |

## Verification
The bench targets window stripping at the smallest and largest window codes, including a table base large enough to need the full 36-bit address. A design that kept the high VA bits or dropped the base's top bits would read the wrong entry. It pairs a read and a write against the same read-only entry: a design that ignored direction would fault both or neither, and would also get the read bit in the status word wrong. Long grant, data and response stalls, with a second request held on the port, catch a design that re-issues the fetch, repeats the interrupt, lets the response drift, or accepts new work early. Entries with the cacheable and write-as-zero bits set, and the byte-lane order, catch decode done on the wrong bits.

// File: rtl/dvma_pkg.sv
package dvma_pkg;

    localparam int VA_W         = 32;
    localparam int PA_W         = 36;
    localparam int BASE_W       = 32;
    localparam int PG_SHIFT     = 12;
    localparam int RANGE_W      = 3;
    localparam int WIN_MIN_LOG2 = 24;
    localparam int PPN_W        = PA_W - PG_SHIFT;

    localparam logic [31:0] FSTAT_WRITE = 32'hC082_0000;
    localparam logic [31:0] FSTAT_RDBIT = 32'h0004_0000;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b11
    } perm_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             cacheable;
        logic [3:0]       spare;
        logic             writable;
        logic             valid;
        logic             waz;
    } pte_t;

    typedef struct packed {
        logic [PA_W-1:0] pa;
        perm_e           perm;
        logic            fault;
        logic [31:0]     status;
        logic [VA_W-1:0] fault_addr;
    } xlate_res_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_RESP
    } xstate_e;

    function automatic logic [VA_W-1:0] win_keep(input logic [RANGE_W-1:0] r);
        logic [VA_W-1:0] one;
        one = 1;
        return (one << (WIN_MIN_LOG2 + int'(r))) - 1;
    endfunction

    function automatic logic [31:0] bswap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/dvma_addr_gen.sv
module dvma_addr_gen
    import dvma_pkg::*;
(
    input  logic [BASE_W-1:0]  cfg_base,
    input  logic [RANGE_W-1:0] cfg_range,
    input  logic [VA_W-1:0]    va,
    output logic [PA_W-1:0]    entry_addr
);
    localparam int IDX_W = VA_W - PG_SHIFT;

    logic [VA_W-1:0]  kept;
    logic [IDX_W-1:0] idx;
    logic [PA_W-1:0]  tbl;
    logic [PA_W-1:0]  off;

    always_comb begin
        kept       = va & win_keep(cfg_range);
        idx        = kept[VA_W-1:PG_SHIFT];
        tbl        = PA_W'({cfg_base, 4'b0000});
        off        = PA_W'({idx, 2'b00});
        entry_addr = tbl + off;
    end

    always_comb begin
        assert (entry_addr[1:0] == 2'b00 || $isunknown(entry_addr))
            else $error("p_word_aligned_r2 failed");
    end
endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check
    import dvma_pkg::*;
#(
    parameter bit SWAP_BYTES = 1'b1
)(
    input  logic [31:0]     raw,
    input  logic [VA_W-1:0] va,
    input  logic            is_write,
    output xlate_res_t      res
);
    logic [31:0] word;
    pte_t        e;
    logic        fault;

    generate
        if (SWAP_BYTES) begin : g_swap
            assign word = bswap32(raw);
        end else begin : g_noswap
            assign word = raw;
        end
    endgenerate

    assign e = pte_t'(word);

    logic unused_pte_bits;
    assign unused_pte_bits = ^{e.cacheable, e.spare, e.waz};

    always_comb begin
        fault = !e.valid || (is_write && !e.writable);
        res   = '0;
        if (fault) begin
            res.fault      = 1'b1;
            res.perm       = PERM_NONE;
            res.status     = FSTAT_WRITE | (is_write ? 32'h0 : FSTAT_RDBIT);
            res.fault_addr = {va[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
        end else begin
            res.pa   = {e.ppn, va[PG_SHIFT-1:0]};
            res.perm = e.writable ? PERM_RW : PERM_RO;
        end
    end

    always_comb begin
        assert (!(res.fault && res.perm != PERM_NONE) || $isunknown(raw))
            else $error("p_fault_noperm_r6 failed");
    end
endmodule

// File: rtl/dvma_ctrl.sv
module dvma_ctrl
    import dvma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_va,
    input  logic            req_write,
    input  logic [PA_W-1:0] entry_addr,
    output logic [VA_W-1:0] va_q,
    output logic            wr_q,
    output logic            mem_req,
    input  logic            mem_gnt,
    output logic [PA_W-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  xlate_res_t      chk_res,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output xlate_res_t      rsp_q,
    output logic            irq_q
);
    xstate_e         state;
    logic [PA_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            va_q   <= '0;
            wr_q   <= 1'b0;
            rsp_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_va;
                        wr_q   <= req_write;
                        addr_q <= entry_addr;
                        state  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_gnt) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        rsp_q <= chk_res;
                        irq_q <= chk_res.fault;
                        state <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign mem_req   = (state == ST_FETCH);
    assign mem_addr  = addr_q;
    assign rsp_valid = (state == ST_RESP);

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req || rsp_valid) |-> !req_ready);

    p_req_held_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> mem_req);

    p_single_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt) |=> !mem_req);

    p_rsp_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_q)));

    p_irq_first_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (rsp_valid && rsp_q.fault && $rose(rsp_valid)));

    p_irq_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (rsp_q.fault_addr[PG_SHIFT-1:0] == '0));

    p_fault_zero_pa_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_q.fault) |-> (rsp_q.pa == '0 && rsp_q.perm == PERM_NONE));
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
    import dvma_pkg::*;
#(
    parameter bit SWAP_BYTES = 1'b1
)(
    input  logic               clk,
    input  logic               rst,
    input  logic [BASE_W-1:0]  cfg_base,
    input  logic [RANGE_W-1:0] cfg_range,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_va,
    input  logic               req_write,
    output logic               mem_req,
    input  logic               mem_gnt,
    output logic [PA_W-1:0]    mem_addr,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_pa,
    output logic [1:0]         rsp_perm,
    output logic               rsp_fault,
    output logic               fault_irq,
    output logic [31:0]        fault_status,
    output logic [VA_W-1:0]    fault_addr
);
    logic [PA_W-1:0] entry_addr;
    logic [VA_W-1:0] va_q;
    logic            wr_q;
    xlate_res_t      chk_res;
    xlate_res_t      rsp_q;

    dvma_addr_gen u_addr (
        .cfg_base   (cfg_base),
        .cfg_range  (cfg_range),
        .va         (req_va),
        .entry_addr (entry_addr)
    );

    dvma_pte_check #(.SWAP_BYTES(SWAP_BYTES)) u_check (
        .raw      (mem_rdata),
        .va       (va_q),
        .is_write (wr_q),
        .res      (chk_res)
    );

    dvma_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_va     (req_va),
        .req_write  (req_write),
        .entry_addr (entry_addr),
        .va_q       (va_q),
        .wr_q       (wr_q),
        .mem_req    (mem_req),
        .mem_gnt    (mem_gnt),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .chk_res    (chk_res),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_q      (rsp_q),
        .irq_q      (fault_irq)
    );

    assign rsp_pa       = rsp_q.pa;
    assign rsp_perm     = rsp_q.perm;
    assign rsp_fault    = rsp_q.fault;
    assign fault_status = rsp_q.status;
    assign fault_addr   = rsp_q.fault_addr;
endmodule

// File: tb/dvma_xlate_bench.sv
`timescale 1ns/1ps
module dvma_xlate_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cfg_base;
    logic [2:0]  cfg_range;
    logic        req_valid, req_ready, req_write;
    logic [31:0] req_va;
    logic        mem_req, mem_gnt, mem_rvalid;
    logic [35:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        rsp_valid, rsp_ready, rsp_fault, fault_irq;
    logic [35:0] rsp_pa;
    logic [1:0]  rsp_perm;
    logic [31:0] fault_status, fault_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dvma_xlate u_dvma_xlate (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_range(cfg_range),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
        .rsp_perm(rsp_perm), .rsp_fault(rsp_fault), .fault_irq(fault_irq),
        .fault_status(fault_status), .fault_addr(fault_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: one full translation with chosen stall lengths.
    task automatic xlate(input logic [31:0] va, input bit wr, input logic [31:0] pte,
                         input logic [31:0] base, input logic [2:0] rng,
                         input int gd, input int rd, input int yd, input bit noise);
        logic [63:0] win;
        logic [35:0] e_addr, e_pa;
        logic [1:0]  e_perm;
        bit          e_fault;
        logic [31:0] e_stat;
        win    = 64'd1 << (24 + rng);
        e_addr = {base, 4'h0} + 36'(((64'(va) % win) >> 12) * 4);
        e_fault = (pte[1] == 1'b0) || (wr && pte[2] == 1'b0);
        e_pa   = e_fault ? 36'h0 : (({4'h0, pte & 32'hFFFF_FF00}) << 4) + 36'(va[11:0]);
        e_perm = e_fault ? 2'b00 : (pte[2] ? 2'b11 : 2'b01);
        e_stat = wr ? 32'hC082_0000 : 32'hC086_0000;

        @(negedge clk);
        cfg_base = base; cfg_range = rng;
        req_va = va; req_write = wr; req_valid = 1'b1;
        chk(req_ready === 1'b1, "R9", "idle ready", 64'(req_ready), 64'd1);
        @(negedge clk);
        if (noise) begin req_va = ~va; req_write = ~wr; end
        else req_valid = 1'b0;
        chk(req_ready === 1'b0, "R9", "busy after accept", 64'(req_ready), 64'd0);
        chk(mem_req === 1'b1, "R9", "fetch issued", 64'(mem_req), 64'd1);
        chk(mem_addr === e_addr, "R2", "entry address", 64'(mem_addr), 64'(e_addr));
        for (int i = 0; i < gd; i++) begin
            @(negedge clk);
            chk(mem_req === 1'b1 && mem_addr === e_addr, "R9", "request held",
                64'(mem_addr), 64'(e_addr));
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        chk(mem_req === 1'b0, "R9", "single fetch", 64'(mem_req), 64'd0);
        for (int i = 0; i < rd; i++) begin
            @(negedge clk);
            chk(mem_req === 1'b0 && rsp_valid === 1'b0 && req_ready === 1'b0, "R9",
                "waiting for data", 64'({mem_req, rsp_valid, req_ready}), 64'd0);
        end
        mem_rvalid = 1'b1;
        mem_rdata  = {pte[7:0], pte[15:8], pte[23:16], pte[31:24]};  // R3 lane order
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = 32'hDEAD_BEEF;
        for (int i = 0; i <= yd; i++) begin
            string rq;
            rq = (i == 0) ? "R4" : "R10";
            chk(rsp_valid === 1'b1 && req_ready === 1'b0, "R9", "response valid, busy",
                64'({rsp_valid, req_ready}), 64'b10);
            chk(rsp_pa === e_pa, rq, "physical address", 64'(rsp_pa), 64'(e_pa));
            chk(rsp_perm === e_perm, e_fault ? "R6" : "R5", "permission",
                64'(rsp_perm), 64'(e_perm));
            chk(rsp_fault === e_fault, "R7", "fault flag", 64'(rsp_fault), 64'(e_fault));
            chk(fault_irq === (e_fault && i == 0), "R8", "irq strobe",
                64'(fault_irq), 64'(e_fault && i == 0));
            if (e_fault) begin
                chk(fault_status === e_stat, "R8", "status word",
                    64'(fault_status), 64'(e_stat));
                chk(fault_addr === (va & 32'hFFFF_F000), "R8", "fault address",
                    64'(fault_addr), 64'(va & 32'hFFFF_F000));
            end
            if (i < yd) @(negedge clk);
        end
        rsp_ready = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rsp_valid === 1'b0 && req_ready === 1'b1 && fault_irq === 1'b0, "R9",
            "back to idle", 64'({rsp_valid, req_ready, fault_irq}), 64'b010);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_base = '0; cfg_range = '0; req_valid = 0; req_va = '0;
        req_write = 0; mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0; rsp_ready = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(req_ready === 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk(mem_req === 1'b0, "R1", "mem_req", 64'(mem_req), 64'd0);
        chk(fault_irq === 1'b0, "R1", "fault_irq", 64'(fault_irq), 64'd0);

        // R4/R5: read-write entry, smallest window
        xlate(32'h0012_3456, 0, 32'h1234_5606, 32'h0000_4000, 3'd0, 0, 0, 0, 0);
        // R7: write to read-only entry faults, read does not
        xlate(32'h00AB_C7FF, 1, 32'hABCD_EF02, 32'h0000_4000, 3'd0, 1, 1, 1, 0);
        xlate(32'h00AB_C7FF, 0, 32'hABCD_EF02, 32'h0000_4000, 3'd0, 0, 2, 0, 0);
        // R6/R8: invalid entry on read
        xlate(32'h0034_5678, 0, 32'h1234_5604, 32'h0001_0000, 3'd2, 0, 0, 0, 0);
        // R2: largest window strips only bit 31
        xlate(32'hFFFF_F123, 0, 32'h0000_0102, 32'h0000_0400, 3'd7, 0, 0, 0, 0);
        // R9/R10: long stalls with a second request held on the port
        xlate(32'hF8AB_C000, 1, 32'h0F0F_0F06, 32'h0000_8000, 3'd3, 4, 5, 4, 1);
        // R4: cacheable and write-as-zero bits set change nothing
        xlate(32'h0100_0ABC, 1, 32'h00AB_C087, 32'h0000_2000, 3'd1, 0, 0, 0, 0);
        // R2: top base bits reach the 36-bit address
        xlate(32'h01FF_F000, 0, 32'hFFFF_FF02, 32'hFFFF_FC00, 3'd1, 1, 0, 0, 0);
        // R8: invalid write with stalled response and noise
        xlate(32'h7654_3210, 1, 32'h0000_0000, 32'h0000_1000, 3'd6, 2, 1, 3, 1);
        // R2/R3 sweep over every window code
        for (int r = 0; r < 8; r++) begin
            xlate(32'h9E37_79B9 * (r + 1), r[0], 32'h1357_9B06 ^ (32'h0101_0100 * r),
                  32'h0003_0000 + 32'(r) * 32'h400, 3'(r), r % 3, r % 2, r % 2, 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule